// File: doc/BRIEF.md
# Serial DMA Request Encoder

The block sits on the peripheral side of a low-pin-count host link. It watches a set of per-channel DMA request levels. For each change it sends a short encoded message on a single active-low request wire, timed by the link clock. Each message names a channel and says whether the request is now raised or withdrawn. When several channels change together, their messages go out back to back, lowest channel first. A channel that needs service while another channel's message is still on the wire joins the queue and is sent straight after it.

A peripheral may abandon a request, for example when its FIFO runs over or under, or when software stops it. If the host still holds a raised request for that channel, the block sends a withdraw message. The block then raises a per-channel flag, because the host can still run a DMA cycle for that channel. The data path uses the flag to either ignore the cycle, so that the host aborts it, or to complete it with arbitrary data.

The data path also reports each DMA cycle the host starts. The block treats that cycle as consuming the request the host held for the channel. Channel 4 is reserved and is never encoded.

Top module: `dma_req_encoder`

## Requirements
- R1: During reset and while idle, the request wire is high and every late-cycle flag is clear.
- R2: A message lasts six clocks on the wire: a low start bit, then the three channel bits with the most significant bit first, then one level bit (1 = raise, 0 = withdraw), then a high stop bit. A message whose channel leaves the idle encoder with a changed request drives its start bit on the first clock after the change.
- R3: When several channels need a message, the lowest-numbered one goes first. The next message's start bit follows the previous stop bit with no idle clock between them.
- R4: A channel whose request rises while another channel's message is in progress is sent immediately after that message.
- R5: A channel is encoded only when its request level differs from the last level the host holds for it. A steady request causes no further traffic.
- R6: When a request falls while the host holds it as raised, a withdraw message (level bit 0) is sent for that channel. This includes a request that falls during its own raise message; the withdraw then follows right after.
- R7: A channel's late-cycle flag is set in the clock that ends its withdraw message. It is cleared by a host cycle report for that channel, or by the start of a new raise message for that channel.
- R8: A host cycle report (cyc_i with the channel on cyc_ch_i) makes the host's view of that channel's request lowered. If the request is still high, a fresh raise message starts two clocks after the report. If the request falls in the same clock as the report, no message is sent.
- R9: Channel 4 is reserved: its request input and cycle reports for it produce no message, and its late-cycle flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_req_i | input | 8 | Request level for each channel, bit n = channel n |
| cyc_i | input | 1 | One-clock pulse: the host has started a DMA cycle |
| cyc_ch_i | input | 3 | Channel of the reported cycle |
| sreq_no | output | 1 | Serial encoded request wire, active low |
| late_o | output | 8 | Per-channel flag: a cycle may still arrive after a withdraw |

## Verification
A request change seen by the idle encoder drives the start bit on the wire after one register stage. The five following bits follow one clock apart, and the next queued message starts on the clock right after the stop bit. A cycle report reaches the wire two clocks later, because it first clears the held level and only then can a new message be picked.

The late-cycle flags change in the same clock as the stop bit of a withdraw message, or one clock after a cycle report. The bench samples the wire and the flags at falling edges. It counts idle clocks before each expected start bit and requires that count to be zero. It reads every bit of the frame at the falling edge that follows its rising edge.

// File: rtl/sdreq_pkg.sv
package sdreq_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_RSV_CH = 4;

  typedef enum logic {
    MSG_WITHDRAW = 1'b0,
    MSG_RAISE    = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/dre_chan_track.sv
module dre_chan_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic start_i,
  input  logic start_act_i,
  input  logic done_i,
  input  logic done_act_i,
  input  logic cyc_i,
  output logic pend_o,
  output logic rep_o,
  output logic late_o
);
  logic rep_q, late_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      // a finished message defines the host view; a cycle consumes it
      if (done_i)     rep_q <= done_act_i;
      else if (cyc_i) rep_q <= 1'b0;

      if (done_i && !done_act_i)               late_q <= 1'b1;
      else if (cyc_i || (start_i && start_act_i)) late_q <= 1'b0;
    end
  end

  // hold off one clock on a cycle report so the cleared view is used
  assign pend_o = (req_i != rep_q) && !cyc_i;
  assign rep_o  = rep_q;
  assign late_o = late_q;
endmodule

// File: rtl/dre_pick.sv
module dre_pick #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] pend_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    vld_o = |pend_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/dre_serializer.sv
module dre_serializer
  import sdreq_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            go_i,
  input  logic [CH_W-1:0]                 chan_i,
  input  logic                            act_i,
  output logic                            line_o,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [CH_W-1:0]                 chan_o,
  output logic                            act_o,
  output logic [$clog2(CH_W+2)-1:0]       cnt_o
);
  localparam int unsigned LEN   = CH_W + 1;
  localparam int unsigned CNT_W = $clog2(LEN + 1);

  logic             busy_q, line_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN-1:0]   sh_q;
  logic [CH_W-1:0]  chan_q;
  msg_kind_e        kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '0;
      chan_q <= '0;
      kind_q <= MSG_WITHDRAW;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        line_q <= 1'b0;
        cnt_q  <= '0;
        sh_q   <= {chan_i, act_i};
        chan_q <= chan_i;
        kind_q <= act_i ? MSG_RAISE : MSG_WITHDRAW;
      end
    end else if (cnt_q == CNT_W'(LEN)) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
    end else begin
      line_q <= sh_q[LEN-1];
      sh_q   <= sh_q << 1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(LEN));
  assign chan_o = chan_q;
  assign act_o  = (kind_q == MSG_RAISE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dma_req_encoder.sv
module dma_req_encoder
  import sdreq_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned RSV_CH = DEF_RSV_CH
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         dma_req_i,
  input  logic                      cyc_i,
  input  logic [$clog2(NUM_CH)-1:0] cyc_ch_i,
  output logic                      sreq_no,
  output logic [NUM_CH-1:0]         late_o
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned CNT_W = $clog2(CH_W + 2);

  logic [NUM_CH-1:0] pend_w, rep_w, late_w;
  logic              pick_vld, pick_act, go;
  logic [CH_W-1:0]   pick_idx, ser_chan;
  logic              ser_busy, ser_done, ser_act, ser_line;
  logic [CNT_W-1:0]  ser_cnt;

  assign go       = pick_vld && !ser_busy;
  assign pick_act = dma_req_i[pick_idx];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == RSV_CH) begin : g_rsv
      // reserved: the input is read by nothing else
      assign pend_w[c] = dma_req_i[c] & 1'b0;
      assign rep_w[c]  = 1'b0;
      assign late_w[c] = 1'b0;
    end else begin : g_trk
      dre_chan_track u_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (dma_req_i[c]),
        .start_i    (go && (pick_idx == CH_W'(c))),
        .start_act_i(pick_act),
        .done_i     (ser_done && (ser_chan == CH_W'(c))),
        .done_act_i (ser_act),
        .cyc_i      (cyc_i && (cyc_ch_i == CH_W'(c))),
        .pend_o     (pend_w[c]),
        .rep_o      (rep_w[c]),
        .late_o     (late_w[c])
      );
    end
  end

  dre_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
    .pend_i(pend_w),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  dre_serializer #(.CH_W(CH_W)) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .chan_i(pick_idx),
    .act_i (pick_act),
    .line_o(ser_line),
    .busy_o(ser_busy),
    .done_o(ser_done),
    .chan_o(ser_chan),
    .act_o (ser_act),
    .cnt_o (ser_cnt)
  );

  assign sreq_no = ser_line;
  assign late_o  = late_w;
endmodule

// File: rtl/dma_req_encoder_chk.sv
module dma_req_encoder_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RSV_CH = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             line_i,
  input logic                             busy_i,
  input logic [$clog2($clog2(NUM_CH)+2)-1:0] cnt_i,
  input logic [$clog2(NUM_CH)-1:0]        chan_i,
  input logic                             act_i,
  input logic [NUM_CH-1:0]                rep_i,
  input logic [NUM_CH-1:0]                late_i
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned LEN   = CH_W + 1;
  localparam int unsigned CNT_W = $clog2(LEN + 1);

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> line_i); // R1

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (cnt_i == '0) |-> !line_i); // R2

  AST_LEVEL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (cnt_i == CNT_W'(LEN)) |-> (line_i == act_i)); // R2

  AST_FRAME_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(chan_i) && $stable(act_i)); // R2

  AST_CHANGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (cnt_i == '0) |-> (rep_i[chan_i] != act_i)); // R5

  AST_NO_RSV_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (chan_i != CH_W'(RSV_CH))); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_late
    AST_LATE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(late_i[c]) |->
        $past(busy_i && (cnt_i == CNT_W'(LEN)) && !act_i && (chan_i == CH_W'(c)))); // R7
  end
endmodule

bind dma_req_encoder dma_req_encoder_chk #(.NUM_CH(NUM_CH), .RSV_CH(RSV_CH)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .line_i(ser_line),
  .busy_i(ser_busy),
  .cnt_i (ser_cnt),
  .chan_i(ser_chan),
  .act_i (ser_act),
  .rep_i (rep_w),
  .late_i(late_w)
);

// File: tb/dma_req_encoder_tb_top.sv
`timescale 1ns/1ps
module dma_req_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] dma_req;
  logic       cyc;
  logic [2:0] cyc_ch;
  logic       sreq_n;
  logic [7:0] late;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_req_encoder dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .dma_req_i(dma_req),
    .cyc_i    (cyc),
    .cyc_ch_i (cyc_ch),
    .sreq_no  (sreq_n),
    .late_o   (late)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_start(output int gap);
    gap = 0;
    @(negedge clk);
    while (sreq_n && gap < 64) begin
      gap++;
      @(negedge clk);
    end
  endtask

  task automatic rd_tail(output int ch, output int lvl, output int stp);
    ch = 0;
    repeat (3) begin
      @(negedge clk);
      ch = ch * 2 + int'(sreq_n);
    end
    @(negedge clk); lvl = int'(sreq_n);
    @(negedge clk); stp = int'(sreq_n);
  endtask

  task automatic expect_msg(input int ch, input int lvl, input string rq);
    int g, c, a, s;
    wait_start(g);
    chk(g == 0, rq, "idle clocks before start", g, 0);
    rd_tail(c, a, s);
    chk(c == ch, rq, "channel", c, ch);
    chk(a == lvl, rq, "level bit", a, lvl);
    chk(s == 1, "R2", "stop bit", s, 1);
  endtask

  task automatic quiet(input int n, input string rq);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!sreq_n) lows++;
    end
    chk(lows == 0, rq, "low clocks on idle wire", lows, 0);
  endtask

  task automatic pulse_cyc(input int c);
    cyc = 1'b1;
    cyc_ch = 3'(c);
    @(negedge clk);
    cyc = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g, c, a, s;
    logic [7:0] exp_late;
    rst_n = 1'b0; dma_req = 8'hFF; cyc = 1'b0; cyc_ch = '0;
    repeat (3) @(negedge clk);
    chk(sreq_n == 1'b1, "R1", "wire in reset", int'(sreq_n), 1);
    chk(late == 8'h00, "R1", "flags in reset", int'(late), 0);
    dma_req = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    quiet(4, "R1");
    chk(late == 8'h00, "R1", "flags idle", int'(late), 0);

    // sweep every request pattern: raise, hold, drop, cycle reports
    for (int m = 0; m < 256; m++) begin
      dma_req = 8'(m);
      for (int ch = 0; ch < 8; ch++)
        if (ch != 4 && m[ch]) expect_msg(ch, 1, "R3");
      quiet(8, "R5");
      dma_req = 8'h00;
      for (int ch = 0; ch < 8; ch++)
        if (ch != 4 && m[ch]) begin
          expect_msg(ch, 0, "R6");
          chk(late[ch] == 1'b1, "R7", "flag after withdraw", int'(late[ch]), 1);
        end
      exp_late = 8'(m) & 8'hEF;
      chk(late == exp_late, "R9", "flag set", int'(late), int'(exp_late));
      for (int ch = 0; ch < 8; ch++) begin
        pulse_cyc(ch);
        chk(late[ch] == 1'b0, "R7", "flag after cycle report", int'(late[ch]), 0);
      end
      quiet(6, "R8");
    end

    // queue behind a message in progress
    dma_req = 8'h04;
    fork
      begin repeat (2) @(negedge clk); dma_req[3] = 1'b1; end
      begin expect_msg(2, 1, "R4"); expect_msg(3, 1, "R4"); end
    join
    dma_req[5] = 1'b1;
    fork
      begin repeat (2) @(negedge clk); dma_req[1] = 1'b1; end
      begin expect_msg(5, 1, "R4"); expect_msg(1, 1, "R3"); end
    join
    quiet(10, "R5");

    // drop during own raise message
    dma_req[6] = 1'b1;
    fork
      begin repeat (2) @(negedge clk); dma_req[6] = 1'b0; end
      begin expect_msg(6, 1, "R6"); expect_msg(6, 0, "R6"); end
    join
    chk(late[6] == 1'b1, "R7", "flag after in-flight drop", int'(late[6]), 1);

    // re-raise clears the flag at its start bit
    dma_req[6] = 1'b1;
    wait_start(g);
    chk(g == 0, "R7", "idle clocks before start", g, 0);
    chk(late[6] == 1'b0, "R7", "flag at new raise", int'(late[6]), 0);
    rd_tail(c, a, s);
    chk(c == 6 && a == 1 && s == 1, "R7", "raise frame channel", c, 6);

    // cycle report with request still high: fresh raise
    pulse_cyc(6);
    expect_msg(6, 1, "R8");
    quiet(4, "R5");
    // cycle report together with a drop: nothing sent
    dma_req[6] = 1'b0;
    pulse_cyc(6);
    quiet(20, "R8");
    chk(late[6] == 1'b0, "R8", "flag after consumed drop", int'(late[6]), 0);

    // reserved channel
    dma_req[4] = 1'b1;
    quiet(12, "R9");
    dma_req[4] = 1'b0;
    quiet(12, "R9");
    pulse_cyc(4);
    quiet(6, "R9");
    chk(late[4] == 1'b0, "R9", "reserved flag", int'(late[4]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule